// File: doc/BRIEF.md
# Filtered Quadrature Decoder Counter

This block turns the two phase signals and the index signal of an incremental encoder into an up/down position count. It counts on every edge of both phases, which gives four counts per encoder line. The phase relationship sets the direction. Each of the three inputs passes through a two-flop synchronizer and then an optional glitch filter. After filtering, each input can be inverted, and the two phases can be swapped. An index pulse either presets the count to zero or is ignored. It is honoured only when the phase levels match one selected combination.

The count wraps between zero and a programmable ceiling. Sticky status flags record a phase error, a wrap in each direction and a change of direction. An interrupt line is raised by any flag whose mask bit is clear. Configuration is loaded from plain input pins with a write strobe. A write is taken only while the block is disabled, so a running count never sees its settings change under it. While disabled, the count holds.

Top module: `qdec_counter`

## Requirements
- R1: After reset, `count` is 0, `status` is 0 and `irq` is 0.
- R2: The levels are written as (A,B), taken after the polarity and swap stages. While enabled, the sequence 00→10→11→01→00 adds one per step and the reverse sequence subtracts one per step.
- R3: With `cfg_swap` set, the two phases exchange roles, so a pin pattern that counts up without the swap counts down with it.
- R4: A `cfg_pol_*` bit of 1 inverts that input after filtering. For an inverted index, a low-going pulse on the pin is the active edge.
- R5: With `cfg_filt_en` set, a level change on a pin is accepted only after it has been seen for `cfg_filt_len`+2 consecutive clocks. With a length of 5, a 6-clock pulse has no effect and a 7-clock pulse is accepted.
- R6: A step up from `count` == ceiling gives 0 and sets status bit 2. A step down from 0 gives the ceiling and sets status bit 1.
- R7: A rising index edge while enabled sets `count` to 0 when (A,B) equals `cfg_idx_gate`, read as {A,B} (0=LL, 1=LH, 2=HL, 3=HH), and `cfg_idx_ignore` is 0. At any other level, or with `cfg_idx_ignore` at 1, the index has no effect.
- R8: A step whose direction differs from the previous step sets status bit 3. The direction after reset is up.
- R9: A sample in which both phases change leaves `count` unchanged and sets status bit 0.
- R10: Status bits stay set until a 1 is written to the same bit of `sts_clr`. `irq` is 1 when any status bit with a clear `irq_mask` bit is set.
- R11: A `cfg_we` strobe while `enable` is 1 changes none of the stored settings.
- R12: While `enable` is 0, `count` holds and phase steps are not counted. The phase levels are still tracked, so re-enabling does not count a step of its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Counting enable; also locks configuration |
| cfg_we | input | 1 | Configuration write strobe (taken only when disabled) |
| cfg_filt_en | input | 1 | Glitch filter enable |
| cfg_filt_len | input | FLT_W | Filter count; hold time is this value plus two clocks |
| cfg_pol_a | input | 1 | Invert phase A |
| cfg_pol_b | input | 1 | Invert phase B |
| cfg_pol_idx | input | 1 | Invert index |
| cfg_swap | input | 1 | Exchange phases A and B |
| cfg_idx_gate | input | 2 | Phase level pair {A,B} in which the index is honoured |
| cfg_idx_ignore | input | 1 | 1: index never presets the count |
| cfg_ceiling | input | CNT_W | Wrap ceiling |
| irq_mask | input | 4 | 1 suppresses the matching status bit from `irq` |
| sts_clr | input | 4 | Write-one-to-clear for status bits |
| enc_a | input | 1 | Encoder phase A pin |
| enc_b | input | 1 | Encoder phase B pin |
| enc_idx | input | 1 | Encoder index pin |
| count | output | CNT_W | Position count |
| status | output | 4 | Sticky flags: 0 phase error, 1 wrap down, 2 wrap up, 3 direction change |
| irq | output | 1 | Interrupt request |

## Verification
A table walks the phases through a full forward cycle, past the ceiling and back down through zero. This separates correct direction decoding from a wrap that fails at either end, and it leaves a known set of status flags behind. Directed patterns then change one factor at a time against the same forward pin sequence. Swap and phase-A inversion each flip the direction. Index pulses at the gated level and at another level, and with the ignore bit set, show whether gating is applied. Pulses one clock shorter and exactly as long as the filter window pin down the acceptance boundary. A jump of both phases at once, a configuration write while running, and a disabled interval show that the error, freeze and hold rules leave the count where it was.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

  localparam int STS_W       = 4;
  localparam int STS_PERR    = 0;
  localparam int STS_WRAP_DN = 1;
  localparam int STS_WRAP_UP = 2;
  localparam int STS_DIR     = 3;

  typedef enum logic [1:0] {
    GATE_LL = 2'd0,
    GATE_LH = 2'd1,
    GATE_HL = 2'd2,
    GATE_HH = 2'd3
  } idx_gate_e;

  typedef struct packed {
    logic      filt_en;
    logic      pol_a;
    logic      pol_b;
    logic      pol_idx;
    logic      swap_ab;
    logic      idx_ignore;
    idx_gate_e idx_gate;
  } ctrl_t;

endpackage

// File: rtl/qdec_filter.sv
module qdec_filter #(
  parameter int FLT_W = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  input  logic             flt_en,
  input  logic [FLT_W-1:0] flt_len,
  output logic             dout
);

  localparam int HC_W = FLT_W + 1;

  logic [1:0]      sync_q;
  logic [HC_W-1:0] hold_cnt;
  logic [HC_W-1:0] hold_lim;

  assign hold_lim = {1'b0, flt_len} + HC_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q   <= '0;
      dout     <= 1'b0;
      hold_cnt <= '0;
    end else begin
      sync_q <= {sync_q[0], din};
      if (!flt_en) begin
        dout     <= sync_q[1];
        hold_cnt <= '0;
      end else if (sync_q[1] == dout) begin
        hold_cnt <= '0;
      end else if (hold_cnt == hold_lim) begin
        dout     <= sync_q[1];
        hold_cnt <= '0;
      end else begin
        hold_cnt <= hold_cnt + HC_W'(1);
      end
    end
  end

endmodule

// File: rtl/qdec_decode.sv
module qdec_decode (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic a,
  input  logic b,
  input  logic idx,
  output logic step,
  output logic up,
  output logic err,
  output logic idx_rise
);

  logic prev_a, prev_b, prev_i;
  logic chg_a, chg_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_a <= 1'b0;
      prev_b <= 1'b0;
      prev_i <= 1'b0;
    end else begin
      prev_a <= a;
      prev_b <= b;
      prev_i <= idx;
    end
  end

  assign chg_a    = a ^ prev_a;
  assign chg_b    = b ^ prev_b;
  assign step     = en & (chg_a ^ chg_b);
  assign err      = en & chg_a & chg_b;
  assign up       = a ^ prev_b;
  assign idx_rise = en & idx & ~prev_i;

endmodule

// File: rtl/qdec_count.sv
module qdec_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             up,
  input  logic             idx_evt,
  input  logic [CNT_W-1:0] ceiling,
  output logic [CNT_W-1:0] count,
  output logic             wrap_up,
  output logic             wrap_dn,
  output logic             dir_chg
);

  logic last_up;
  logic live_step;

  assign live_step = step & ~idx_evt;
  assign wrap_up   = live_step &  up & (count == ceiling);
  assign wrap_dn   = live_step & ~up & (count == '0);
  assign dir_chg   = live_step & (up != last_up);

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      last_up <= 1'b1;
    end else if (idx_evt) begin
      count <= '0;
    end else if (step) begin
      last_up <= up;
      if (up) count <= wrap_up ? '0 : count + CNT_W'(1);
      else    count <= wrap_dn ? ceiling : count - CNT_W'(1);
    end
  end

endmodule

// File: rtl/qdec_counter.sv
module qdec_counter #(
  parameter int CNT_W = 32,
  parameter int FLT_W = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             cfg_we,
  input  logic             cfg_filt_en,
  input  logic [FLT_W-1:0] cfg_filt_len,
  input  logic             cfg_pol_a,
  input  logic             cfg_pol_b,
  input  logic             cfg_pol_idx,
  input  logic             cfg_swap,
  input  logic [1:0]       cfg_idx_gate,
  input  logic             cfg_idx_ignore,
  input  logic [CNT_W-1:0] cfg_ceiling,
  input  logic [3:0]       irq_mask,
  input  logic [3:0]       sts_clr,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic             enc_idx,
  output logic [CNT_W-1:0] count,
  output logic [3:0]       status,
  output logic             irq
);
  import qdec_pkg::*;

  localparam int NCH = 3;

  ctrl_t                  ctrl_q;
  logic [FLT_W-1:0]       flen_q;
  logic [CNT_W-1:0]       ceil_q;
  logic [NCH-1:0]         pin_raw;
  logic [NCH-1:0]         pin_flt;
  logic                   pa, pb, pi, da, db;
  logic                   step, up, dec_err, idx_rise, idx_evt, gate_ok;
  logic                   wrap_up, wrap_dn, dir_chg;
  logic [STS_W-1:0]       sts_set, sts_next, sts_q;
  logic                   irq_q;

  // configuration registers, locked while counting
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      flen_q <= '0;
      ceil_q <= '0;
    end else if (cfg_we && !enable) begin
      ctrl_q.filt_en    <= cfg_filt_en;
      ctrl_q.pol_a      <= cfg_pol_a;
      ctrl_q.pol_b      <= cfg_pol_b;
      ctrl_q.pol_idx    <= cfg_pol_idx;
      ctrl_q.swap_ab    <= cfg_swap;
      ctrl_q.idx_ignore <= cfg_idx_ignore;
      ctrl_q.idx_gate   <= idx_gate_e'(cfg_idx_gate);
      flen_q            <= cfg_filt_len;
      ceil_q            <= cfg_ceiling;
    end
  end

  assign pin_raw = {enc_idx, enc_b, enc_a};

  for (genvar g = 0; g < NCH; g++) begin : g_pin
    qdec_filter #(.FLT_W(FLT_W)) i_filter (
      .clk     (clk),
      .rst     (rst),
      .din     (pin_raw[g]),
      .flt_en  (ctrl_q.filt_en),
      .flt_len (flen_q),
      .dout    (pin_flt[g])
    );
  end

  assign pa = pin_flt[0] ^ ctrl_q.pol_a;
  assign pb = pin_flt[1] ^ ctrl_q.pol_b;
  assign pi = pin_flt[2] ^ ctrl_q.pol_idx;
  assign da = ctrl_q.swap_ab ? pb : pa;
  assign db = ctrl_q.swap_ab ? pa : pb;

  qdec_decode i_decode (
    .clk      (clk),
    .rst      (rst),
    .en       (enable),
    .a        (da),
    .b        (db),
    .idx      (pi),
    .step     (step),
    .up       (up),
    .err      (dec_err),
    .idx_rise (idx_rise)
  );

  assign gate_ok = ({da, db} == ctrl_q.idx_gate);
  assign idx_evt = idx_rise & gate_ok & ~ctrl_q.idx_ignore;

  qdec_count #(.CNT_W(CNT_W)) i_count (
    .clk     (clk),
    .rst     (rst),
    .step    (step),
    .up      (up),
    .idx_evt (idx_evt),
    .ceiling (ceil_q),
    .count   (count),
    .wrap_up (wrap_up),
    .wrap_dn (wrap_dn),
    .dir_chg (dir_chg)
  );

  always_comb begin
    sts_set              = '0;
    sts_set[STS_PERR]    = dec_err;
    sts_set[STS_WRAP_DN] = wrap_dn;
    sts_set[STS_WRAP_UP] = wrap_up;
    sts_set[STS_DIR]     = dir_chg;
    sts_next             = (sts_q & ~sts_clr) | sts_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= '0;
      irq_q <= 1'b0;
    end else begin
      sts_q <= sts_next;
      irq_q <= |(sts_next & ~irq_mask);
    end
  end

  assign status = sts_q;
  assign irq    = irq_q;

endmodule

// File: rtl/qdec_counter_chk.sv
module qdec_counter_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] ceil_q,
  input logic [3:0]       status,
  input logic [3:0]       sts_clr,
  input logic [3:0]       irq_mask,
  input logic             irq,
  input logic             dec_err,
  input logic             idx_evt
);

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !enable |=> $stable(count)); // R12

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    enable |=> $stable(ceil_q)); // R11

  AST_STICKY_FLAGS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status & ($past(status) & ~$past(sts_clr))) ==
              ($past(status) & ~$past(sts_clr)))); // R10

  AST_MASK_ALL_QUIET: assert property (@(posedge clk) disable iff (rst)
    (&irq_mask) |=> !irq); // R10

  AST_PERR_NO_STEP: assert property (@(posedge clk) disable iff (rst)
    (dec_err && !idx_evt) |=> ($stable(count) && status[qdec_pkg::STS_PERR])); // R9

endmodule

bind qdec_counter qdec_counter_chk #(.CNT_W(CNT_W)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .enable   (enable),
  .count    (count),
  .ceil_q   (ceil_q),
  .status   (status),
  .sts_clr  (sts_clr),
  .irq_mask (irq_mask),
  .irq      (irq),
  .dec_err  (dec_err),
  .idx_evt  (idx_evt)
);

// File: tb/test_qdec_counter.sv
`timescale 1ns/1ps
module test_qdec_counter;

  localparam int CNT_W = 32;
  localparam int FLT_W = 21;
  localparam int NVEC  = 10;

  // {A, B, expected count} with ceiling 5
  localparam logic [33:0] VEC [NVEC] = '{
    {2'b10, 32'd1}, {2'b11, 32'd2}, {2'b01, 32'd3}, {2'b00, 32'd4},
    {2'b10, 32'd5}, {2'b11, 32'd0}, {2'b10, 32'd5}, {2'b00, 32'd4},
    {2'b01, 32'd3}, {2'b11, 32'd2}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             enable = 1'b0;
  logic             cfg_we = 1'b0;
  logic             cfg_filt_en = 1'b0;
  logic [FLT_W-1:0] cfg_filt_len = '0;
  logic             cfg_pol_a = 1'b0;
  logic             cfg_pol_b = 1'b0;
  logic             cfg_pol_idx = 1'b0;
  logic             cfg_swap = 1'b0;
  logic [1:0]       cfg_idx_gate = 2'd0;
  logic             cfg_idx_ignore = 1'b0;
  logic [CNT_W-1:0] cfg_ceiling = '0;
  logic [3:0]       irq_mask = 4'hF;
  logic [3:0]       sts_clr = 4'h0;
  logic             enc_a = 1'b0;
  logic             enc_b = 1'b0;
  logic             enc_idx = 1'b0;
  logic [CNT_W-1:0] count;
  logic [3:0]       status;
  logic             irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  qdec_counter #(.CNT_W(CNT_W), .FLT_W(FLT_W)) i_qdec_counter (
    .clk(clk), .rst(rst), .enable(enable), .cfg_we(cfg_we),
    .cfg_filt_en(cfg_filt_en), .cfg_filt_len(cfg_filt_len),
    .cfg_pol_a(cfg_pol_a), .cfg_pol_b(cfg_pol_b), .cfg_pol_idx(cfg_pol_idx),
    .cfg_swap(cfg_swap), .cfg_idx_gate(cfg_idx_gate),
    .cfg_idx_ignore(cfg_idx_ignore), .cfg_ceiling(cfg_ceiling),
    .irq_mask(irq_mask), .sts_clr(sts_clr),
    .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
    .count(count), .status(status), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart();
    @(negedge clk);
    rst = 1'b1; enable = 1'b0; enc_a = 1'b0; enc_b = 1'b0; enc_idx = 1'b0;
    sts_clr = 4'h0; irq_mask = 4'hF;
    idle(2);
    rst = 1'b0;
    idle(1);
  endtask

  task automatic cfg_write(input logic [31:0] ceil, input logic swp, input logic pola,
                           input logic poli, input logic [1:0] gate, input logic ign,
                           input logic fe, input logic [FLT_W-1:0] fl);
    @(negedge clk);
    cfg_ceiling = ceil; cfg_swap = swp; cfg_pol_a = pola; cfg_pol_b = 1'b0;
    cfg_pol_idx = poli; cfg_idx_gate = gate; cfg_idx_ignore = ign;
    cfg_filt_en = fe; cfg_filt_len = fl; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    idle(8);
  endtask

  task automatic ab(input logic a, input logic b);
    @(negedge clk);
    enc_a = a; enc_b = b;
    idle(12);
  endtask

  task automatic idx_pulse(input logic active, input int n);
    @(negedge clk);
    enc_idx = active;
    idle(n);
    enc_idx = ~active;
    idle(12);
  endtask

  task automatic a_pulse(input int n);
    @(negedge clk);
    enc_a = 1'b1;
    idle(n);
    enc_a = 1'b0;
    idle(30);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    restart();
    chk("R1 count", count, 0);
    chk("R1 status", {28'd0, status}, 0);
    chk("R1 irq", {31'd0, irq}, 0);

    // R2, R6, R8: vector table with ceiling 5
    cfg_write(32'd5, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0, '0);
    @(negedge clk); enable = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      ab(VEC[i][33], VEC[i][32]);
      chk($sformatf("R2/R6 vector %0d", i), count, VEC[i][31:0]);
    end
    chk("R6 R8 status after table", {28'd0, status}, 32'hE);

    // R10 mask and clear
    irq_mask = 4'hF; idle(3);
    chk("R10 irq all masked", {31'd0, irq}, 0);
    irq_mask = 4'h7; idle(3);
    chk("R10 irq dir unmasked", {31'd0, irq}, 1);
    sts_clr = 4'h8; idle(1); sts_clr = 4'h0; idle(3);
    chk("R10 status after clear", {28'd0, status}, 32'h6);
    chk("R10 irq after clear", {31'd0, irq}, 0);

    // R3 swap reverses direction
    restart();
    cfg_write(32'd1000, 1'b1, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0, '0);
    @(negedge clk); enable = 1'b1;
    ab(1'b1, 1'b0); ab(1'b1, 1'b1);
    chk("R3 swapped count", count, 999);

    // R4 inverting phase A reverses direction
    restart();
    cfg_write(32'd1000, 1'b0, 1'b1, 1'b0, 2'd3, 1'b0, 1'b0, '0);
    @(negedge clk); enable = 1'b1;
    ab(1'b1, 1'b0); ab(1'b1, 1'b1);
    chk("R4 inverted A count", count, 999);

    // R5 filter boundary, length 5 -> 7 clocks
    restart();
    cfg_write(32'd1000, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 1'b1, 21'd5);
    @(negedge clk); enable = 1'b1;
    a_pulse(6);
    chk("R5 short pulse count", count, 0);
    chk("R5 short pulse status", {28'd0, status}, 0);
    a_pulse(7);
    chk("R5 R8 full pulse status", {28'd0, status}, 32'h8);
    chk("R5 full pulse count", count, 0);

    // R7 index gating and preset
    restart();
    cfg_write(32'd1000, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0, '0);
    @(negedge clk); enable = 1'b1;
    ab(1'b1, 1'b0); ab(1'b1, 1'b1);
    chk("R7 before index", count, 2);
    idx_pulse(1'b1, 5);
    chk("R7 index at gated level", count, 0);
    ab(1'b0, 1'b1); ab(1'b0, 1'b0);
    idx_pulse(1'b1, 5);
    chk("R7 index at other level", count, 2);

    restart();
    cfg_write(32'd1000, 1'b0, 1'b0, 1'b0, 2'd3, 1'b1, 1'b0, '0);
    @(negedge clk); enable = 1'b1;
    ab(1'b1, 1'b0); ab(1'b1, 1'b1);
    idx_pulse(1'b1, 5);
    chk("R7 index ignored", count, 2);

    // R4 R7 inverted index, gate 0 (A low, B low)
    restart();
    cfg_write(32'd1000, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, '0);
    @(negedge clk); enc_idx = 1'b1; idle(10);
    enable = 1'b1;
    ab(1'b1, 1'b0); ab(1'b1, 1'b1); ab(1'b0, 1'b1); ab(1'b0, 1'b0);
    chk("R4 R7 before low index", count, 4);
    idx_pulse(1'b0, 5);
    chk("R4 R7 low-going index presets", count, 0);

    // R9 both phases change at once
    restart();
    cfg_write(32'd1000, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0, '0);
    @(negedge clk); enable = 1'b1;
    ab(1'b1, 1'b1);
    chk("R9 count unchanged", count, 0);
    chk("R9 phase error flag", {28'd0, status}, 32'h1);

    // R11 write while enabled ignored, R12 hold while disabled
    restart();
    cfg_write(32'd1000, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0, '0);
    @(negedge clk); enable = 1'b1;
    @(negedge clk);
    cfg_ceiling = 32'd2; cfg_swap = 1'b1; cfg_we = 1'b1;
    @(negedge clk); cfg_we = 1'b0;
    ab(1'b1, 1'b0); ab(1'b1, 1'b1); ab(1'b0, 1'b1);
    chk("R11 settings kept", count, 3);
    @(negedge clk); enable = 1'b0;
    ab(1'b0, 1'b0);
    chk("R12 disabled hold", count, 3);
    @(negedge clk); enable = 1'b1; idle(5);
    chk("R12 no step on enable", count, 3);
    ab(1'b1, 1'b0);
    chk("R12 resumes from tracked level", count, 4);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule